// File: doc/BRIEF.md
# Relative Branch Resolver

This block takes one relative branch per request. It decides whether the branch is taken and works out the program counter that follows it. The request carries the following:

- the address of the branch instruction;
- a signed byte of displacement;
- the four arithmetic status flags (negative, zero, overflow, carry);
- a five-bit condition selector;
- a two-bit length selector.

For the two bit-test forms, the request also carries a data byte and a mask. The block does not fetch or decode instructions. It expects a decoder upstream that has already read the operands.

When the branch is not taken, the result is the address of the next sequential instruction. That address is the branch address plus the instruction length. When the branch is taken, the sign-extended displacement is added to that sequential address. All address arithmetic wraps modulo 2^16. The result is registered and returns one clock after the request. Requests may be sent back to back on every cycle.

Top module: `branch_resolve`

## Requirements
- R1: While `rst_n` is low, `rsp_vld`, `rsp_taken` and `rsp_pc` are all 0.
- R2: A request accepted on a clock edge with `req_vld` high gives `rsp_vld` high after that same edge, for exactly one cycle per request. When `req_vld` is low, `rsp_vld` falls and `rsp_taken`/`rsp_pc` keep their last values.
- R3: The sequential address is `req_pc + 2 + req_len`, modulo 2^16. A length code of 0, 1, 2 or 3 gives an instruction length of 2, 3, 4 or 5 bytes. An untaken branch returns this address.
- R4: A taken branch returns the sequential address plus `req_disp` read as two's complement (-128..+127), modulo 2^16. For example, pc 0xB607 with length code 0 and displacement 0xF7 goes to 0xB600.
- R5: Single-flag conditions: code 4 is taken when C=0, code 5 when C=1, code 6 when Z=0, code 7 when Z=1, code 8 when V=0, code 9 when V=1, code 10 when N=0, and code 11 when N=1.
- R6: Signed conditions use only N, Z and V:
  - code 12 (greater or equal) is taken when N equals V;
  - code 13 (less than) is taken when N differs from V;
  - code 14 (greater than) is taken when Z=0 and N equals V;
  - code 15 (less or equal) is taken when Z=1 or N differs from V.
- R7: Unsigned conditions use only C and Z: code 2 (higher) is taken when C=0 and Z=0, and code 3 (lower or same) is taken when C=1 or Z=1.
- R8: Code 0 is always taken and code 1 is never taken, whatever the flags.
- R9: Code 16 (bits set) is taken only when every bit that is 1 in `req_mask` is also 1 in `req_mem`. An all-zero mask is therefore always taken.
- R10: Code 17 (bits clear) is taken when `req_mem & req_mask` is zero.
- R11: Codes 18 to 31 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_pc | input | 16 | Address of the branch instruction |
| req_disp | input | 8 | Two's-complement displacement |
| req_cond | input | 5 | Condition selector (see R5-R11 for codes) |
| req_len | input | 2 | Instruction length minus 2 |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| req_mem | input | 8 | Data byte for the bit-test forms |
| req_mask | input | 8 | Bit mask for the bit-test forms |
| rsp_vld | output | 1 | Result strobe |
| rsp_taken | output | 1 | Branch taken |
| rsp_pc | output | 16 | Next program counter |

## Verification
Both results, the taken flag and the next PC, are due in the cycle after the edge that accepts the request. There is one register between the inputs and the outputs and no other path. The driver changes inputs on falling edges and queues one expected item per request. The monitor samples on the following falling edge, half a period after the capturing rising edge, and takes one item from the queue each time `rsp_vld` is high. A strobe with nothing pending, or an item still left at the end, counts as a mismatch. The hold behaviour is checked on an idle falling edge after the queue has drained.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [4:0]        req_cond,
  input  logic [1:0]        req_len,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [DATA_W-1:0] req_mem,
  input  logic [DATA_W-1:0] req_mask,
  output logic              rsp_vld,
  output logic              rsp_taken,
  output logic [PC_W-1:0]   rsp_pc
);

  localparam int LEN_BASE = 2;
  localparam logic [4:0] COND_NEVER = 5'd1;
  localparam logic [4:0] COND_BSET  = 5'd16;
  localparam logic [4:0] COND_BCLR  = 5'd17;

  // Even code of each pair is the positive sense; odd code inverts it.
  logic [7:0]        pair_true;
  logic              flag_hit;
  logic              bit_hit;
  logic              hit;
  logic [DATA_W-1:0] masked;
  logic [PC_W-1:0]   seq_pc;
  logic [PC_W-1:0]   disp_ext;
  logic [PC_W-1:0]   tgt_pc;

  logic nv;
  assign nv = flag_n ^ flag_v;

  assign pair_true = {~(flag_z | nv), ~nv, ~flag_n, ~flag_v,
                      ~flag_z, ~flag_c, ~(flag_c | flag_z), 1'b1};
  assign flag_hit  = pair_true[req_cond[3:1]] ^ req_cond[0];

  assign masked = req_mem & req_mask;
  always_comb begin
    case (req_cond)
      COND_BSET: bit_hit = (masked == req_mask);
      COND_BCLR: bit_hit = (masked == '0);
      default:   bit_hit = 1'b0;
    endcase
  end

  assign hit = req_cond[4] ? bit_hit : flag_hit;

  assign seq_pc   = req_pc + PC_W'(LEN_BASE) + PC_W'(req_len);
  assign disp_ext = {{(PC_W-DISP_W){req_disp[DISP_W-1]}}, req_disp};
  assign tgt_pc   = seq_pc + disp_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_taken <= 1'b0;
      rsp_pc    <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_taken <= hit;
        rsp_pc    <= hit ? tgt_pc : seq_pc;
      end
    end
  end

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_vld && $stable(rsp_pc) && $stable(rsp_taken)));

  // R3
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cond == COND_NEVER) |=>
      (rsp_pc == $past(req_pc) + PC_W'(LEN_BASE) + PC_W'($past(req_len))));

  // R8
  never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cond == COND_NEVER) |=> !rsp_taken);

  // R9
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cond == COND_BSET && req_mask == '0) |=> rsp_taken);

  // R11
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cond > COND_BCLR) |=> !rsp_taken);

endmodule

// File: tb/test_branch_resolve.sv
module test_branch_resolve;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [15:0] req_pc = '0;
  logic [7:0]  req_disp = '0;
  logic [4:0]  req_cond = '0;
  logic [1:0]  req_len = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic [7:0]  req_mem = '0, req_mask = '0;
  logic        rsp_vld, rsp_taken;
  logic [15:0] rsp_pc;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic        taken;
    logic [15:0] pc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve i_branch_resolve (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_pc(req_pc),
    .req_disp(req_disp), .req_cond(req_cond), .req_len(req_len),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .req_mem(req_mem), .req_mask(req_mask),
    .rsp_vld(rsp_vld), .rsp_taken(rsp_taken), .rsp_pc(rsp_pc));

  function automatic logic model_taken(input logic [4:0] cond, input logic n, z, v, c,
                                       input logic [7:0] mem, mask);
    case (cond)
      5'd0:  return 1'b1;
      5'd1:  return 1'b0;
      5'd2:  return !c && !z;
      5'd3:  return c || z;
      5'd4:  return !c;
      5'd5:  return c;
      5'd6:  return !z;
      5'd7:  return z;
      5'd8:  return !v;
      5'd9:  return v;
      5'd10: return !n;
      5'd11: return n;
      5'd12: return n == v;
      5'd13: return n != v;
      5'd14: return !z && (n == v);
      5'd15: return z || (n != v);
      5'd16: return (mem & mask) == mask;
      5'd17: return (mem & mask) == 8'h00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] model_pc(input logic [15:0] pc, input logic [7:0] d,
                                           input logic [1:0] len, input logic tk);
    int sd;
    int r;
    sd = (d >= 8'd128) ? int'(d) - 256 : int'(d);
    r = int'(pc) + 2 + int'(len) + (tk ? sd : 0);
    return 16'(r & 16'hFFFF);
  endfunction

  function automatic string req_of(input logic [4:0] cond);
    if (cond <= 5'd1) return "R8";
    if (cond <= 5'd3) return "R7";
    if (cond <= 5'd11) return "R5";
    if (cond <= 5'd15) return "R6";
    if (cond == 5'd16) return "R9";
    if (cond == 5'd17) return "R10";
    return "R11";
  endfunction

  task automatic send(input logic [15:0] pc, input logic [7:0] d, input logic [4:0] cond,
                      input logic [1:0] len, input logic [3:0] nzvc,
                      input logic [7:0] mem, input logic [7:0] mask, input string tag);
    exp_t e;
    @(negedge clk);
    req_vld = 1'b1; req_pc = pc; req_disp = d; req_cond = cond; req_len = len;
    {flag_n, flag_z, flag_v, flag_c} = nzvc;
    req_mem = mem; req_mask = mask;
    e.taken = model_taken(cond, nzvc[3], nzvc[2], nzvc[1], nzvc[0], mem, mask);
    e.pc = model_pc(pc, d, len, e.taken);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act, exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 strobe with nothing pending", 32'(rsp_vld), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_taken === e.taken, {e.tag, " taken"}, 32'(rsp_taken), 32'(e.taken));
        check(rsp_pc === e.pc, {e.tag, " pc"}, 32'(rsp_pc), 32'(e.pc));
      end
    end
  end

  task automatic finish_run();
    check(sb.size() == 0, "R2 responses outstanding", 32'(sb.size()), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rsp_vld === 1'b0, "R1 rsp_vld", 32'(rsp_vld), 32'd0);
    check(rsp_taken === 1'b0, "R1 rsp_taken", 32'(rsp_taken), 32'd0);
    check(rsp_pc === 16'h0000, "R1 rsp_pc", 32'(rsp_pc), 32'd0);
    rst_n = 1'b1;

    // R5 R6 R7 R8: every flag-condition code against every flag pattern
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        send(16'h4000 + 16'(cc * 37 + f * 5), 8'(f * 17 + cc), 5'(cc), 2'(f),
             4'(f), 8'h00, 8'h00, req_of(5'(cc)));
      end
    end

    // R11 reserved codes, with flags and bytes that would satisfy any test
    for (int cc = 18; cc < 32; cc++) begin
      send(16'h2000 + 16'(cc), 8'h10, 5'(cc), 2'd0, 4'hF, 8'hFF, 8'h00, "R11");
      send(16'h2100 + 16'(cc), 8'h10, 5'(cc), 2'd1, 4'h0, 8'h00, 8'hFF, "R11");
    end

    // R9 bits set
    send(16'h0010, 8'h08, 5'd16, 2'd2, 4'h0, 8'h1F, 8'h05, "R9 all selected set");
    send(16'h0010, 8'h08, 5'd16, 2'd2, 4'hF, 8'h1A, 8'h05, "R9 none selected set");
    send(16'h0010, 8'h08, 5'd16, 2'd3, 4'h0, 8'h01, 8'h05, "R9 partial");
    send(16'h0010, 8'hF0, 5'd16, 2'd1, 4'h0, 8'h00, 8'h00, "R9 empty mask");
    send(16'h8000, 8'h80, 5'd16, 2'd3, 4'h5, 8'hFF, 8'hFF, "R9 full mask");
    // R10 bits clear
    send(16'h0020, 8'h04, 5'd17, 2'd2, 4'hF, 8'h1A, 8'h05, "R10 selected clear");
    send(16'h0020, 8'h04, 5'd17, 2'd3, 4'h0, 8'h1F, 8'h05, "R10 one selected set");
    send(16'h0020, 8'hFC, 5'd17, 2'd0, 4'h0, 8'hFF, 8'h00, "R10 empty mask");

    // R4 targets and wrap
    send(16'hB607, 8'hF7, 5'd0, 2'd0, 4'h0, 8'h00, 8'h00, "R4 backward loop");
    send(16'hFFFE, 8'h7F, 5'd0, 2'd0, 4'h0, 8'h00, 8'h00, "R4 wrap up");
    send(16'h0000, 8'h80, 5'd0, 2'd3, 4'h0, 8'h00, 8'h00, "R4 wrap down");
    send(16'h1000, 8'hFE, 5'd0, 2'd0, 4'h0, 8'h00, 8'h00, "R4 self loop");

    // R3 lengths
    for (int l = 0; l < 4; l++) begin
      send(16'h1234, 8'h40, 5'd1, 2'(l), 4'hF, 8'h00, 8'h00, "R3 length");
    end
    send(16'hFFFF, 8'h40, 5'd1, 2'd3, 4'h0, 8'h00, 8'h00, "R3 wrap");
    send(16'hC000, 8'h33, 5'd7, 2'd2, 4'h0, 8'h00, 8'h00, "R3 false condition");

    // R2 idle hold: last response was not taken, 0xC000+4
    idle();
    repeat (3) @(negedge clk);
    check(rsp_vld === 1'b0, "R2 idle strobe", 32'(rsp_vld), 32'd0);
    check(rsp_pc === 16'hC004, "R2 idle pc hold", 32'(rsp_pc), 32'hC004);
    check(rsp_taken === 1'b0, "R2 idle taken hold", 32'(rsp_taken), 32'd0);

    // R2 single request after a gap
    send(16'h5000, 8'h02, 5'd0, 2'd0, 4'h0, 8'h00, 8'h00, "R2 isolated");
    idle();
    repeat (2) @(negedge clk);
    check(rsp_pc === 16'h5004, "R2 pc after gap", 32'(rsp_pc), 32'h5004);

    finish_run();
  end
endmodule